// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Status Tags

This block sits between a UART receiver and the host. The receiver hands over each decoded character, with its framing-error, parity-error and break indications, on a valid/ready push port. The block stores each character with its condition bits in a 32-entry first-in first-out queue. The head entry is shown to the host as a 16-bit tagged word on a valid/ready pop port.

Alongside the data the block produces plain status outputs. A data-ready flag is high whenever anything is held. A trigger-ready flag compares the occupancy against a programmable level. Empty and full flags follow the queue. A sticky overrun flag and a sticky break flag complete the set.

Back-pressure rules: `in_ready` is low exactly when the queue holds 32 entries. The serial line cannot be stalled, so a character offered while `in_ready` is low is dropped and recorded as an overrun; it is not held for a later cycle. On the pop side, `out_valid` equals "not empty". A pop happens on any edge where `out_ready` and `out_valid` are both high. `out_ready` while empty is ignored. A push is judged against the occupancy before the edge, so a push to a full queue is dropped even if a pop happens in the same cycle.

Top module: `uart_rxq_top`

## Requirements
- R1: A held entry reads as: bit 15 = 1 (valid), bit 14 = OR of bits 13..10, bit 13 = overrun, bit 12 = framing error, bit 11 = break, bit 10 = parity error, bits 9..8 = 0, bits 7..0 = character.
- R2: When `cfg_eight_bit` is 0 at push time, bit 7 of the stored character reads as 0; when it is 1, all 8 bits are kept.
- R3: Entries leave in arrival order. The queue holds 32 entries. `st_full` is high at 32 entries, `st_empty` is high at 0 entries, and `in_ready` equals not `st_full`.
- R4: `st_data_ready` is high whenever at least one entry is held, and stays high across pops until the queue is empty.
- R5: `st_trig_ready` is high when the occupancy is greater than or equal to `rx_trig_lvl` (a level of 0 keeps it high).
- R6: A push offered while full is dropped and sets the sticky `st_overrun`. The next entry that is stored carries the overrun bit (bit 13), and therefore bit 14 as well.
- R7: While the queue is empty, `out_word` is 16'h0000 with the valid bit clear, and `out_ready` has no effect: the next stored entry is the one read next.
- R8: `st_break` is set by any offered character with the break indication, whether stored or dropped. It stays set until a cycle with `brk_clr` high; a new break in that same cycle wins.
- R9: A cycle with `soft_rst` high empties the queue and clears `st_overrun`, `st_break` and any pending overrun tag. A push offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of queue and sticky flags |
| cfg_eight_bit | input | 1 | 1: 8-bit characters, 0: 7-bit characters |
| rx_trig_lvl | input | 6 | Occupancy level for trigger-ready |
| in_valid | input | 1 | Receiver offers a character |
| in_ready | output | 1 | Queue can store the offered character |
| in_char | input | 8 | Decoded character |
| in_frame_err | input | 1 | Framing error on this character |
| in_parity_err | input | 1 | Parity error on this character |
| in_break | input | 1 | Break detected with this character |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Host consumes the head entry |
| out_word | output | 16 | Tagged head word |
| st_data_ready | output | 1 | At least one entry held |
| st_trig_ready | output | 1 | Occupancy at or above trigger level |
| st_empty | output | 1 | Queue empty |
| st_full | output | 1 | Queue full |
| st_overrun | output | 1 | Sticky: a character was dropped |
| st_break | output | 1 | Sticky: break seen |
| brk_clr | input | 1 | Write-one-to-clear for `st_break` |

## Verification
A wrong read or write pointer shows at once on `out_word`: the next pop returns a character out of order or a stale one. An occupancy count that is off by one moves `st_full`, `in_ready` and `st_trig_ready` by one push. That is caught in the cycle after the push at the fill and trigger boundaries. A lost pending-overrun tag only shows at the first store after the drop, so the bench empties the queue and stores once more to see it. The sticky flags are compared in the cycle after each set, clear and software reset.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int CHAR_W = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              brk;
    logic              pe;
    logic [CHAR_W-1:0] ch;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);

  function automatic logic [WORD_W-1:0] entry_to_word(input rxq_entry_t e, input logic present);
    logic [WORD_W-1:0] w;
    w = '0;
    if (present) begin
      w[15]          = 1'b1;
      w[14]          = e.ovr | e.fe | e.brk | e.pe;
      w[13]          = e.ovr;
      w[12]          = e.fe;
      w[11]          = e.brk;
      w[10]          = e.pe;
      w[CHAR_W-1:0]  = e.ch;
    end
    return w;
  endfunction
endpackage

// File: rtl/uart_rxq_pack.sv
module uart_rxq_pack
  import uart_rxq_pkg::*;
(
  input  logic [CHAR_W-1:0] ch,
  input  logic              eight_bit,
  input  logic              fe,
  input  logic              pe,
  input  logic              brk,
  input  logic              ovr_pending,
  output rxq_entry_t        entry
);
  logic [CHAR_W-1:0] mask;

  always_comb begin
    mask = '1;
    if (!eight_bit) mask[CHAR_W-1] = 1'b0;
    entry.ch  = ch & mask;
    entry.fe  = fe;
    entry.pe  = pe;
    entry.brk = brk;
    entry.ovr = ovr_pending;
  end
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 32,
  parameter int W     = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CFULL);
  assign do_wr = wr_en && !full && !clr;
  assign do_rd = rd_en && !empty && !clr;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= advance(wr_ptr);
      if (do_rd) rd_ptr <= advance(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxq_flags.sv
module uart_rxq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drop,
  input  logic stored,
  input  logic brk_seen,
  input  logic brk_clr,
  output logic ovr_pending,
  output logic ovr_sticky,
  output logic brk_sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pending <= 1'b0;
      ovr_sticky  <= 1'b0;
      brk_sticky  <= 1'b0;
    end else if (clr) begin
      ovr_pending <= 1'b0;
      ovr_sticky  <= 1'b0;
      brk_sticky  <= 1'b0;
    end else begin
      if (drop)        ovr_pending <= 1'b1;
      else if (stored) ovr_pending <= 1'b0;
      if (drop)        ovr_sticky  <= 1'b1;
      if (brk_seen)     brk_sticky <= 1'b1;
      else if (brk_clr) brk_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TRIG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_eight_bit,
  input  logic [TRIG_W-1:0] rx_trig_lvl,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_frame_err,
  input  logic              in_parity_err,
  input  logic              in_break,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              st_data_ready,
  output logic              st_trig_ready,
  output logic              st_empty,
  output logic              st_full,
  output logic              st_overrun,
  output logic              st_break,
  input  logic              brk_clr
);
  localparam int CW = $clog2(DEPTH + 1);

  rxq_entry_t    wr_entry, rd_entry;
  logic [CW-1:0] count;
  logic          empty, full, ovr_pending;
  logic          push, pop, drop;

  assign push = in_valid && !full && !soft_rst;
  assign drop = in_valid &&  full && !soft_rst;
  assign pop  = out_ready && !empty && !soft_rst;

  uart_rxq_pack u_pack (
    .ch          (in_char),
    .eight_bit   (cfg_eight_bit),
    .fe          (in_frame_err),
    .pe          (in_parity_err),
    .brk         (in_break),
    .ovr_pending (ovr_pending),
    .entry       (wr_entry)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .wr_en   (push),
    .wr_data (wr_entry),
    .rd_en   (pop),
    .rd_data (rd_entry),
    .count   (count),
    .empty   (empty),
    .full    (full)
  );

  uart_rxq_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (soft_rst),
    .drop        (drop),
    .stored      (push),
    .brk_seen    (in_valid && in_break),
    .brk_clr     (brk_clr),
    .ovr_pending (ovr_pending),
    .ovr_sticky  (st_overrun),
    .brk_sticky  (st_break)
  );

  assign in_ready      = !full;
  assign out_valid     = !empty;
  assign out_word      = entry_to_word(rd_entry, !empty);
  assign st_empty      = empty;
  assign st_full       = full;
  assign st_data_ready = !empty;
  assign st_trig_ready = int'(count) >= int'(rx_trig_lvl);
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        in_valid,
  input logic        in_break,
  input logic        in_ready,
  input logic        out_valid,
  input logic [15:0] out_word,
  input logic        st_empty,
  input logic        st_full,
  input logic        st_data_ready,
  input logic        st_overrun,
  input logic        st_break,
  input logic        brk_clr
);
  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty));
  // R3
  ready_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !st_full);
  // R4
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_ready == out_valid);
  // R1
  valid_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[15]);
  // R7
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (out_word == 16'h0000));
  // R7
  empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_empty && !in_valid) |=> st_empty);
  // R6
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !soft_rst) |=> st_overrun);
  // R8
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_break && !soft_rst) |=> st_break);
  // R8
  brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !(in_valid && in_break)) |=> !st_break);
  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_empty && !st_overrun && !st_break));
endmodule

bind uart_rxq_top uart_rxq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .in_valid      (in_valid),
  .in_break      (in_break),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_word      (out_word),
  .st_empty      (st_empty),
  .st_full       (st_full),
  .st_data_ready (st_data_ready),
  .st_overrun    (st_overrun),
  .st_break      (st_break),
  .brk_clr       (brk_clr)
);

// File: tb/tb_uart_rxq_top.sv
`timescale 1ns/100ps
module tb_uart_rxq_top;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, cfg_eight_bit = 1'b1;
  logic [5:0] rx_trig_lvl = 6'd1;
  logic in_valid = 1'b0, in_frame_err = 1'b0, in_parity_err = 1'b0, in_break = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic out_ready = 1'b0, brk_clr = 1'b0;
  logic in_ready, out_valid, st_data_ready, st_trig_ready, st_empty, st_full, st_overrun, st_break;
  logic [15:0] out_word;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rxq_top dut (.*);

  // {char[27:20], fe[19], pe[18], brk[17], eight_bit[16], expected word[15:0]}
  localparam logic [27:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h80A5},
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8025},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 16'hD03C},
    {8'h7E, 1'b0, 1'b1, 1'b0, 1'b1, 16'hC47E},
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 16'hD800},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h807F},
    {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 16'hD401},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 16'h805A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c, input logic fe, input logic pe, input logic bk);
    @(negedge clk);
    in_valid = 1'b1; in_char = c; in_frame_err = fe; in_parity_err = pe; in_break = bk;
    @(negedge clk);
    in_valid = 1'b0; in_frame_err = 1'b0; in_parity_err = 1'b0; in_break = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [15:0] exp);
    @(negedge clk);
    check(req, out_word, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R3 empty at reset", {15'd0, st_empty}, 16'd1);
    check("R3 full at reset", {15'd0, st_full}, 16'd0);
    check("R4 data ready at reset", {15'd0, st_data_ready}, 16'd0);
    check("R7 word at reset", out_word, 16'h0000);
    check("R8 break at reset", {15'd0, st_break}, 16'd0);

    // table walk: tagging and 7/8-bit handling (R1, R2)
    foreach (VEC[i]) begin
      cfg_eight_bit = VEC[i][16];
      push(VEC[i][27:20], VEC[i][19], VEC[i][18], VEC[i][17]);
    end
    cfg_eight_bit = 1'b1;
    check("R4 data ready with 8 held", {15'd0, st_data_ready}, 16'd1);
    foreach (VEC[i]) begin
      pop_check("R1 R2 tagged word", VEC[i][15:0]);
      if (i < 7) check("R4 stays ready", {15'd0, st_data_ready}, 16'd1);
    end
    check("R4 drops when empty", {15'd0, st_data_ready}, 16'd0);
    check("R8 break sticky after pops", {15'd0, st_break}, 16'd1);
    @(negedge clk); brk_clr = 1'b1;
    @(negedge clk); brk_clr = 1'b0;
    check("R8 break cleared", {15'd0, st_break}, 16'd0);
    // break set wins over clear in same cycle
    @(negedge clk);
    brk_clr = 1'b1; in_valid = 1'b1; in_char = 8'h00; in_break = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0; in_valid = 1'b0; in_break = 1'b0;
    check("R8 set beats clear", {15'd0, st_break}, 16'd1);
    pop_check("R1 break word", 16'hC800);
    @(negedge clk); brk_clr = 1'b1;
    @(negedge clk); brk_clr = 1'b0;

    // empty read ignored (R7)
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check("R7 empty read word", out_word, 16'h0000);
    push(8'h42, 1'b0, 1'b0, 1'b0);
    pop_check("R7 next entry after empty read", 16'h8042);

    // trigger level and fill (R5, R3)
    rx_trig_lvl = 6'd5;
    for (int k = 0; k < 32; k++) begin
      push(8'(k), 1'b0, 1'b0, 1'b0);
      if (k == 3) check("R5 below level", {15'd0, st_trig_ready}, 16'd0);
      if (k == 4) check("R5 at level", {15'd0, st_trig_ready}, 16'd1);
      if (k == 30) check("R3 not full at 31", {15'd0, st_full}, 16'd0);
    end
    check("R3 full at 32", {15'd0, st_full}, 16'd1);
    check("R3 ready low when full", {15'd0, in_ready}, 16'd0);
    check("R6 no overrun yet", {15'd0, st_overrun}, 16'd0);
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    check("R6 overrun sticky", {15'd0, st_overrun}, 16'd1);
    for (int k = 0; k < 32; k++) pop_check("R3 order", {8'h80, 8'(k)});
    check("R3 empty after drain", {15'd0, st_empty}, 16'd1);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h12, 1'b0, 1'b0, 1'b0);
    pop_check("R6 tag on next stored", 16'hE011);
    pop_check("R6 tag only once", 16'h8012);
    check("R6 overrun still set", {15'd0, st_overrun}, 16'd1);

    // soft reset (R9)
    push(8'h33, 1'b0, 1'b0, 1'b1);
    push(8'h34, 1'b0, 1'b0, 1'b0);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R9 empty after soft reset", {15'd0, st_empty}, 16'd1);
    check("R9 overrun cleared", {15'd0, st_overrun}, 16'd0);
    check("R9 break cleared", {15'd0, st_break}, 16'd0);
    push(8'h55, 1'b0, 1'b0, 1'b0);
    pop_check("R9 fresh entry", 16'h8055);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule